// File: doc/BRIEF.md
# Masked Summary Interrupt Aggregator

This block folds three grouped interrupt sources (receive, transmit and miscellaneous) into a single interrupt line for a host. Each group offers one level that means "this group has at least one unmasked cause pending". The block latches those levels into a three-bit summary cause register. The bits stay set until the host reads that register, and the read itself acts as the acknowledge. No separate clear write is needed.

A software mask register gates each latched summary bit before the output line is formed. A mask bit of one blocks its group. The mask comes out of reset with every bit set, so the line stays quiet until software opens it. Writing all ones closes the line entirely. Writing the complement of the three group positions opens all three sources. A read returns what was captured since the previous read, not a live OR of the inputs. A source that fires in the same cycle as the clearing read is carried forward and not dropped. Only three bits exist, so a read can never show all ones in its low byte. A host can therefore treat a zero value, or a value with an all-ones low byte, as a spurious or absent interrupt.

Top module: `aggr_irq_summary`

## Requirements
- R1: After a synchronous active-low reset, the summary cause register reads zero, the mask register reads 0x7 (all stored bits set), and `irq_out` is low.
- R2: A high level on `grp_pending[i]` sets summary bit i (receive = bit 0, transmit = bit 1, miscellaneous = bit 2) at the next clock edge. The bit stays set after the input falls, until a clearing read.
- R3: A read of address 0 (cause) presents the captured summary value on `reg_rdata` in the cycle after the read strobe, and clears the summary bits at that same edge.
- R4: A group input that is high in the same cycle as a clearing read leaves its summary bit set after the read. The read itself returns the value held before that edge.
- R5: `irq_out` is high exactly when some summary bit is set and its mask bit is zero. It follows register state in the same cycle, with no extra delay.
- R6: With all mask bits set (for example after writing 0xFFFFFFFF to address 1), `irq_out` stays low whatever summary bits are latched.
- R7: Writing to address 1 loads mask bit i from `reg_wdata[i]`. Writing 0xFFFFFFF8 unmasks all three groups. Other patterns mask each group individually.
- R8: Bits above position 2 read as zero from every address. The mask register keeps only its three low bits, so reading address 1 returns the mask zero-extended.
- R9: Reads of address 1 (mask) and of addresses 2 and 3 leave the summary bits unchanged. Addresses 2 and 3 read zero. Writes to addresses 0, 2 and 3 change neither register.
- R10: The low byte of `reg_rdata` is never 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (2) | Word address: 0 cause, 1 mask, 2 and 3 unused |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, registered, valid the cycle after `reg_rd` |
| grp_pending | input | 3 | Per-group pending levels: bit 0 receive, bit 1 transmit, bit 2 miscellaneous |
| irq_out | output | 1 | Summary interrupt line |

## Verification
A group level or a mask write presented before a clock edge shows on `irq_out` right after that edge. A read strobe returns its data one edge later, and the clear happens at that same edge. The bench drives every input on the falling edge. Its driver tasks push each expected read value into a queue. The monitor pops that value on the falling edge after the read strobe was sampled, so every comparison lands half a cycle after the edge that produced the result. Line checks are made at the falling edge that follows the stimulus edge. The same-cycle case lines up a group pulse with a clearing read in one cycle, then reads again, to separate the returned snapshot from the carried-forward bit.

// File: rtl/aggr_irq_pkg.sv
package aggr_irq_pkg;

  localparam int NUM_GROUPS = 3;
  localparam int GRP_RX     = 0;
  localparam int GRP_TX     = 1;
  localparam int GRP_MISC   = 2;

  localparam int ADDR_CAUSE = 0;
  localparam int ADDR_MASK  = 1;

  typedef logic [NUM_GROUPS-1:0] grp_vec_t;

  // Summary state after one edge: new events always win over a clear.
  function automatic grp_vec_t cause_next(grp_vec_t held, grp_vec_t events, logic clr);
    grp_vec_t kept;
    kept = clr ? '0 : held;
    return kept | events;
  endfunction

  // Interrupt request from latched causes and mask (1 blocks).
  function automatic logic irq_of(grp_vec_t held, grp_vec_t blk);
    return |(held & ~blk);
  endfunction

endpackage

// File: rtl/aggr_cause_latch.sv
module aggr_cause_latch
  import aggr_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  grp_vec_t grp_in,
  input  logic     rd_clr,
  output grp_vec_t cause_q
);

  grp_vec_t cause_d;

  always_comb cause_d = cause_next(cause_q, grp_in, rd_clr);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) cause_q[g] <= 1'b0;
      else        cause_q[g] <= cause_d[g];
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R3
  cleared_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((cause_q & ~$past(grp_in)) == '0));

  // R4
  no_event_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_in != '0) |=> ((cause_q & $past(grp_in)) == $past(grp_in)));

endmodule

// File: rtl/aggr_mask_reg.sv
module aggr_mask_reg
  import aggr_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  grp_vec_t wr_val,
  output grp_vec_t mask_q
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)     mask_q[g] <= 1'b1;
      else if (wr_en) mask_q[g] <= wr_val[g];
    end
  end

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/aggr_read_port.sv
module aggr_read_port
  import aggr_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  grp_vec_t          cause,
  input  grp_vec_t          mask,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(ADDR_CAUSE))     sel[NUM_GROUPS-1:0] = cause;
    else if (addr == ADDR_W'(ADDR_MASK)) sel[NUM_GROUPS-1:0] = mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

endmodule

// File: rtl/aggr_irq_summary.sv
module aggr_irq_summary
  import aggr_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_GROUPS-1:0] grp_pending,
  output logic                  irq_out
);

  logic     rd_cause_ev;
  logic     wr_mask_ev;
  grp_vec_t cause_q;
  grp_vec_t mask_q;
  logic     unused_wdata_hi;

  assign rd_cause_ev     = reg_rd && (reg_addr == ADDR_W'(ADDR_CAUSE));
  assign wr_mask_ev      = reg_wr && (reg_addr == ADDR_W'(ADDR_MASK));
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_GROUPS];

  aggr_cause_latch u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .grp_in  (grp_pending),
    .rd_clr  (rd_cause_ev),
    .cause_q (cause_q)
  );

  aggr_mask_reg u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_mask_ev),
    .wr_val (reg_wdata[NUM_GROUPS-1:0]),
    .mask_q (mask_q)
  );

  aggr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (reg_rd),
    .addr  (reg_addr),
    .cause (cause_q),
    .mask  (mask_q),
    .rdata (reg_rdata)
  );

  assign irq_out = irq_of(cause_q, mask_q);

  // R6
  closed_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

  // R8
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_GROUPS] == '0);

  // R10
  low_byte_not_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:0] != 8'hFF);

  // R3
  read_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cause_ev |=> (reg_rdata[NUM_GROUPS-1:0] == $past(cause_q)));

endmodule

// File: tb/tb_aggr_irq_summary.sv
`timescale 1ns/1ps
module tb_aggr_irq_summary;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  grp_pending = '0;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit rd_seen  = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  aggr_irq_summary dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_pending(grp_pending), .irq_out(irq_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: the read strobe sampled at an edge yields data by the next falling edge
  always @(posedge clk) rd_seen <= reg_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (q.size() == 0) chk(32'h1, 32'h0, "scoreboard underflow");
      else begin
        exp_t e;
        e = q.pop_front();
        chk(reg_rdata, e.exp, e.tag);
        // R10 low byte never all ones
        chk({31'd0, reg_rdata[7:0] == 8'hFF}, 32'd0, {"R10 ", e.tag});
      end
    end
  end

  task automatic rd_reg(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    q.push_back('{exp: e, tag: t});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk);
    grp_pending = v;
    @(negedge clk);
    grp_pending = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    chk({31'd0, irq_out}, {31'd0, e}, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_irq(1'b0, "R1 irq low after reset");
    rd_reg(2'd0, 32'h0, "R1 cause zero after reset");
    rd_reg(2'd1, 32'h7, "R1 R8 mask all set after reset");

    // masked event: latched but line stays low
    pulse(3'b001);
    chk_irq(1'b0, "R6 closed mask keeps line low");
    rd_reg(2'd0, 32'h1, "R2 R3 receive bit captured");
    rd_reg(2'd0, 32'h0, "R3 cleared by previous read");

    // open all three groups
    wr_reg(2'd1, 32'hFFFF_FFF8);
    rd_reg(2'd1, 32'h0, "R7 R8 unmask all readback");
    pulse(3'b010);
    chk_irq(1'b1, "R5 transmit raises line");
    rd_reg(2'd0, 32'h2, "R2 transmit bit captured");
    chk_irq(1'b0, "R5 R3 line drops after clearing read");

    // event coincident with clearing read
    @(negedge clk);
    grp_pending = 3'b100; reg_rd = 1'b1; reg_addr = 2'd0;
    q.push_back('{exp: 32'h0, tag: "R4 coincident read returns old value"});
    @(negedge clk);
    grp_pending = '0; reg_rd = 1'b0;
    chk_irq(1'b1, "R4 R5 carried bit drives line");
    rd_reg(2'd0, 32'h4, "R4 misc bit survived read");
    pulse(3'b100);
    @(negedge clk);
    grp_pending = 3'b100; reg_rd = 1'b1; reg_addr = 2'd0;
    q.push_back('{exp: 32'h4, tag: "R4 read with bit already set"});
    @(negedge clk);
    grp_pending = '0; reg_rd = 1'b0;
    rd_reg(2'd0, 32'h4, "R4 bit kept when re-asserted during read");

    // per-bit mask: only transmit open
    wr_reg(2'd1, 32'hFFFF_FFFD);
    pulse(3'b001);
    chk_irq(1'b0, "R7 masked receive keeps line low");
    pulse(3'b010);
    chk_irq(1'b1, "R7 open transmit raises line");
    rd_reg(2'd3, 32'h0, "R9 unused address reads zero");
    rd_reg(2'd1, 32'h5, "R8 R9 mask readback zero-extended");
    rd_reg(2'd2, 32'h0, "R9 unused address 2 reads zero");
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd1, 32'h5, "R9 writes elsewhere leave mask");
    rd_reg(2'd0, 32'h3, "R9 cause kept across other accesses");

    // all three latched and then closed
    wr_reg(2'd1, 32'h0);
    pulse(3'b111);
    chk_irq(1'b1, "R5 all groups raise line");
    wr_reg(2'd1, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R6 all-ones mask silences latched causes");
    rd_reg(2'd0, 32'h7, "R2 R10 all three captured");
    rd_reg(2'd0, 32'h0, "R3 all cleared");

    repeat (3) @(negedge clk);
    chk(q.size(), 32'd0, "scoreboard drained");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule